// File: doc/BRIEF.md
# Control Pin and Reset Manager

This block sits between a register-programmed audio processing core and the chip's pins. It brings two external control levels into the clock domain through synchronisers and shows them in a status register. The first level acts as a write lock for volume coefficients. The second level has two uses. When the spectrum analyser is switched on, it holds the analyser band registers at zero. When the analyser is off, it is only a status bit that the host can read. Two general-purpose output pins follow bits that the host writes.

Reset comes from two sources, and they reach different amounts of state. The active-low hardware reset pin is asserted asynchronously and released synchronously. While it is active, every host register returns to its default, the algorithm is held in restart and the serial data line is released. The software reset is bit 15 of the register at address 0xFFD. It gives a one-cycle restart pulse and clears the output pins, and every other register keeps its value. When a volume write is refused, the write is dropped and a sticky flag records it.

Top module: `ctlpin_rst_mgr`

## Requirements
- R1: A host write to a volume address (0x000 to 0x00F) appears on `vol_we_o`, `vol_idx_o` and `vol_data_o` in the same cycle when synchronised control input 1 is 0. When that input is 1, `vol_we_o` stays 0.
- R2: A volume write refused by R1 is dropped and never replayed. It sets status bit 2 (sticky). Writing 1 to bit 2 of the status register (0xFF2) clears the flag.
- R3: With the analyser enabled (bit 0 of the mode register 0xFF1 = 1), `band_clr_o` is high in every cycle in which synchronised control input 2 is 1.
- R4: With the analyser disabled, `band_clr_o` stays 0 whatever level input 2 has. The level of input 2 can still be read in status bit 1.
- R5: Status bit 0 shows control input 1 and status bit 1 shows control input 2, each after a two-edge synchroniser. A level change is visible after the second rising edge and not after the first.
- R6: `gp_out_o[1:0]` takes bits [1:0] of a write to the output register 0xFF0 on the next edge, and the register reads back the same value.
- R7: While `rst_pin_n` is low, these take effect without waiting for a clock: `gp_out_o` = 0, analyser enable = 0, sticky flag = 0, `alg_restart_o` = 1 and `sda_hiz_o` = 1.
- R8: After `rst_pin_n` rises, `alg_restart_o` and `sda_hiz_o` stay 1 after the first rising edge and fall after the second.
- R9: A write to 0xFFD with bit 15 set makes `alg_restart_o` high for exactly the next cycle. Bit 15 of 0xFFD reads 1 in that cycle only. `gp_out_o` is cleared. The analyser enable and the sticky flag keep their values.
- R10: A write to 0xFFD with bit 15 clear changes nothing: there is no restart pulse and the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Hardware reset pin, active low |
| ctl_in1_i | input | 1 | Control level 1 (volume write lock), asynchronous |
| ctl_in2_i | input | 1 | Control level 2 (analyser clear or status), asynchronous |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 12 | Host register address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Read data for `host_addr_i` (combinational) |
| vol_we_o | output | 1 | Gated volume coefficient write strobe |
| vol_idx_o | output | 4 | Volume coefficient index |
| vol_data_o | output | 16 | Volume coefficient data |
| band_clr_o | output | 1 | Hold analyser band registers at zero |
| ana_en_o | output | 1 | Analyser enable |
| alg_restart_o | output | 1 | Algorithm restart |
| sda_hiz_o | output | 1 | Request to release the serial data line |
| gp_out_o | output | 2 | General-purpose output pins |

## Verification
The hardest state to reach from the ports is one where the two reset sources meet state that has already been changed. For this, the output pins, the analyser enable and the sticky flag must all be away from their defaults at the moment a reset arrives. The stimulus first sets up that state: it programs the outputs, enables the analyser and makes a refused volume write while input 1 is held high. It then issues a software reset and checks what was cleared and what was kept. After that it pulls the reset pin low in the middle of a cycle and checks that everything clears before the next edge. A full sweep over both input levels, the analyser mode and all output values checks the gating and the readback of every combination.

// File: rtl/cpr_pkg.sv
`timescale 1ns/1ps
package cpr_pkg;
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_VOL,
      SEL_OUT,
      SEL_MODE,
      SEL_STAT,
      SEL_SWRST
   } reg_sel_e;

   localparam int STAT_IN1_BIT = 0;
   localparam int STAT_IN2_BIT = 1;
   localparam int STAT_BLK_BIT = 2;
   localparam int STAT_BITS    = 3;
endpackage

// File: rtl/cpr_sync.sv
`timescale 1ns/1ps
module cpr_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cpr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cpr_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cpr_rst_sync.sv
`timescale 1ns/1ps
module cpr_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_pin_n,
   output logic rst_int_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cpr_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n) shift_q <= '0;
      else            shift_q <= {shift_q[STAGES-2:0], 1'b1};
   end

   assign rst_int_n = shift_q[STAGES-1];
endmodule

// File: rtl/cpr_hostregs.sv
`timescale 1ns/1ps
module cpr_hostregs #(
   parameter int N_OUT            = 2,
   parameter bit ANALYSER_PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_out_i,
   input  logic [N_OUT-1:0] out_val_i,
   input  logic             wr_mode_i,
   input  logic             mode_val_i,
   input  logic             blk_clr_i,
   input  logic             swrst_req_i,
   input  logic             blk_set_i,
   output logic [N_OUT-1:0] gp_out_o,
   output logic             ana_en_o,
   output logic             blk_o,
   output logic             swrst_o
);
   // output latches: software reset wins over a plain write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           gp_out_o <= '0;
      else if (swrst_req_i) gp_out_o <= '0;
      else if (wr_out_i)    gp_out_o <= out_val_i;
   end

   // self-clearing restart request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) swrst_o <= 1'b0;
      else        swrst_o <= swrst_req_i;
   end

   // sticky refused-write flag: a new refusal wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         blk_o <= 1'b0;
      else if (blk_set_i) blk_o <= 1'b1;
      else if (blk_clr_i) blk_o <= 1'b0;
   end

   if (ANALYSER_PRESENT) begin : g_ana
      logic ana_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ana_q <= 1'b0;
         else if (wr_mode_i) ana_q <= mode_val_i;
      end
      assign ana_en_o = ana_q;
   end else begin : g_no_ana
      logic unused_mode;
      assign unused_mode = wr_mode_i ^ mode_val_i;
      assign ana_en_o    = 1'b0;
   end
endmodule

// File: rtl/ctlpin_rst_mgr.sv
`timescale 1ns/1ps
module ctlpin_rst_mgr
   import cpr_pkg::*;
#(
   parameter int          ADDR_W           = 12,
   parameter int          DATA_W           = 16,
   parameter int          N_OUT            = 2,
   parameter int          SYNC_STAGES      = 2,
   parameter int unsigned VOL_BASE         = 'h000,
   parameter int unsigned VOL_COUNT        = 16,
   parameter int unsigned OUT_ADDR         = 'hFF0,
   parameter int unsigned MODE_ADDR        = 'hFF1,
   parameter int unsigned STAT_ADDR        = 'hFF2,
   parameter int unsigned SWRST_ADDR       = 'hFFD,
   parameter int          SWRST_BIT        = 15,
   parameter bit          ANALYSER_PRESENT = 1'b1,
   localparam int         VOL_IDX_W        = (VOL_COUNT > 1) ? $clog2(VOL_COUNT) : 1
) (
   input  logic                 clk,
   input  logic                 rst_pin_n,
   input  logic                 ctl_in1_i,
   input  logic                 ctl_in2_i,
   input  logic                 host_we_i,
   input  logic [ADDR_W-1:0]    host_addr_i,
   input  logic [DATA_W-1:0]    host_wdata_i,
   output logic [DATA_W-1:0]    host_rdata_o,
   output logic                 vol_we_o,
   output logic [VOL_IDX_W-1:0] vol_idx_o,
   output logic [DATA_W-1:0]    vol_data_o,
   output logic                 band_clr_o,
   output logic                 ana_en_o,
   output logic                 alg_restart_o,
   output logic                 sda_hiz_o,
   output logic [N_OUT-1:0]     gp_out_o
);
   localparam logic [ADDR_W-1:0] VOL_BASE_A = ADDR_W'(VOL_BASE);
   localparam logic [ADDR_W-1:0] VOL_CNT_A  = ADDR_W'(VOL_COUNT);
   localparam logic [ADDR_W-1:0] OUT_A      = ADDR_W'(OUT_ADDR);
   localparam logic [ADDR_W-1:0] MODE_A     = ADDR_W'(MODE_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A     = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] SWRST_A    = ADDR_W'(SWRST_ADDR);

   // elaboration-time parameter checks
   if (DATA_W < STAT_BITS || N_OUT < 1 || N_OUT > DATA_W) begin : g_bad_width
      $error("ctlpin_rst_mgr: DATA_W/N_OUT out of range");
   end
   if (SWRST_BIT < 0 || SWRST_BIT >= DATA_W) begin : g_bad_swbit
      $error("ctlpin_rst_mgr: SWRST_BIT outside data word");
   end
   if (VOL_COUNT < 1 || VOL_BASE + VOL_COUNT > OUT_ADDR) begin : g_bad_vol
      $error("ctlpin_rst_mgr: volume window overlaps control registers");
   end
   if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_addr
      $error("ctlpin_rst_mgr: ADDR_W out of range");
   end

   // reset: asynchronous assert, synchronous release
   logic rst_int_n;
   cpr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk       (clk),
      .rst_pin_n (rst_pin_n),
      .rst_int_n (rst_int_n)
   );

   // control input synchronisers
   logic [1:0] ctl_s;
   logic       in1_s;
   logic       in2_s;
   cpr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_in_sync (
      .clk   (clk),
      .rst_n (rst_int_n),
      .d_i   ({ctl_in2_i, ctl_in1_i}),
      .q_o   (ctl_s)
   );
   assign in1_s = ctl_s[0];
   assign in2_s = ctl_s[1];

   // address decode
   logic [ADDR_W-1:0] vol_off;
   reg_sel_e          sel;
   assign vol_off = host_addr_i - VOL_BASE_A;

   always_comb begin
      if (vol_off < VOL_CNT_A)         sel = SEL_VOL;
      else if (host_addr_i == OUT_A)   sel = SEL_OUT;
      else if (host_addr_i == MODE_A)  sel = SEL_MODE;
      else if (host_addr_i == STAT_A)  sel = SEL_STAT;
      else if (host_addr_i == SWRST_A) sel = SEL_SWRST;
      else                             sel = SEL_NONE;
   end

   logic wr_ok;
   logic vol_try;
   logic swrst_req;
   assign wr_ok     = host_we_i && rst_int_n;
   assign vol_try   = wr_ok && (sel == SEL_VOL);
   assign swrst_req = wr_ok && (sel == SEL_SWRST) && host_wdata_i[SWRST_BIT];

   // volume write gate
   assign vol_we_o   = vol_try && !in1_s;
   assign vol_idx_o  = vol_off[VOL_IDX_W-1:0];
   assign vol_data_o = host_wdata_i;

   logic blk_q;
   logic swrst_q;
   cpr_hostregs #(
      .N_OUT            (N_OUT),
      .ANALYSER_PRESENT (ANALYSER_PRESENT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .wr_out_i    (wr_ok && (sel == SEL_OUT)),
      .out_val_i   (host_wdata_i[N_OUT-1:0]),
      .wr_mode_i   (wr_ok && (sel == SEL_MODE)),
      .mode_val_i  (host_wdata_i[0]),
      .blk_clr_i   (wr_ok && (sel == SEL_STAT) && host_wdata_i[STAT_BLK_BIT]),
      .swrst_req_i (swrst_req),
      .blk_set_i   (vol_try && in1_s),
      .gp_out_o    (gp_out_o),
      .ana_en_o    (ana_en_o),
      .blk_o       (blk_q),
      .swrst_o     (swrst_q)
   );

   // analyser clear: level-sensitive, mode dependent
   if (ANALYSER_PRESENT) begin : g_clr
      assign band_clr_o = ana_en_o && in2_s;
   end else begin : g_no_clr
      assign band_clr_o = 1'b0;
   end

   assign alg_restart_o = !rst_int_n || swrst_q;
   assign sda_hiz_o     = !rst_int_n;

   // read mux
   always_comb begin
      host_rdata_o = '0;
      unique case (sel)
         SEL_OUT:   host_rdata_o[N_OUT-1:0] = gp_out_o;
         SEL_MODE:  host_rdata_o[0]         = ana_en_o;
         SEL_STAT: begin
            host_rdata_o[STAT_IN1_BIT] = in1_s;
            host_rdata_o[STAT_IN2_BIT] = in2_s;
            host_rdata_o[STAT_BLK_BIT] = blk_q;
         end
         SEL_SWRST: host_rdata_o[SWRST_BIT] = swrst_q;
         default:   host_rdata_o = '0;
      endcase
   end
endmodule

module cpr_checker #(
   parameter int          ADDR_W           = 12,
   parameter int          DATA_W           = 16,
   parameter int          N_OUT            = 2,
   parameter int          SYNC_STAGES      = 2,
   parameter int unsigned VOL_BASE         = 'h000,
   parameter int unsigned VOL_COUNT        = 16,
   parameter int unsigned OUT_ADDR         = 'hFF0,
   parameter int unsigned SWRST_ADDR       = 'hFFD,
   parameter int          SWRST_BIT        = 15,
   parameter bit          ANALYSER_PRESENT = 1'b1
) (
   input logic              clk,
   input logic              rst_pin_n,
   input logic              rst_int_n,
   input logic              host_we_i,
   input logic [ADDR_W-1:0] host_addr_i,
   input logic [DATA_W-1:0] host_wdata_i,
   input logic              in1_s,
   input logic              ctl_in2_i,
   input logic              vol_we_o,
   input logic              band_clr_o,
   input logic              ana_en_o,
   input logic              blk_q,
   input logic              alg_restart_o,
   input logic [N_OUT-1:0]  gp_out_o
);
   logic [ADDR_W-1:0] off;
   logic              is_vol;
   assign off    = host_addr_i - ADDR_W'(VOL_BASE);
   assign is_vol = off < ADDR_W'(VOL_COUNT);

   assert_vol_gate_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
      vol_we_o |-> (host_we_i && !in1_s && is_vol));

   assert_blocked_sticky_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
      (host_we_i && is_vol && in1_s) |=> blk_q);

   if (ANALYSER_PRESENT && SYNC_STAGES == 2) begin : g_clr_chk
      assert_band_clr_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
         band_clr_o |-> (ana_en_o && $past(ctl_in2_i, 2)));
   end

   assert_no_clr_disabled_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
      !ana_en_o |-> !band_clr_o);

   assert_out_follow_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
      (host_we_i && host_addr_i == ADDR_W'(OUT_ADDR)) |=>
         (gp_out_o == $past(host_wdata_i[N_OUT-1:0])));

   if (SYNC_STAGES == 2) begin : g_rel_chk
      assert_release_R8: assert property (@(posedge clk) disable iff (!rst_pin_n)
         $rose(rst_int_n) |-> $past(rst_pin_n, 2));
   end

   assert_swrst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
      (host_we_i && host_addr_i == ADDR_W'(SWRST_ADDR) && host_wdata_i[SWRST_BIT]) |=>
         (alg_restart_o && gp_out_o == '0));
endmodule

bind ctlpin_rst_mgr cpr_checker #(
   .ADDR_W           (ADDR_W),
   .DATA_W           (DATA_W),
   .N_OUT            (N_OUT),
   .SYNC_STAGES      (SYNC_STAGES),
   .VOL_BASE         (VOL_BASE),
   .VOL_COUNT        (VOL_COUNT),
   .OUT_ADDR         (OUT_ADDR),
   .SWRST_ADDR       (SWRST_ADDR),
   .SWRST_BIT        (SWRST_BIT),
   .ANALYSER_PRESENT (ANALYSER_PRESENT)
) u_chk (
   .clk           (clk),
   .rst_pin_n     (rst_pin_n),
   .rst_int_n     (rst_int_n),
   .host_we_i     (host_we_i),
   .host_addr_i   (host_addr_i),
   .host_wdata_i  (host_wdata_i),
   .in1_s         (in1_s),
   .ctl_in2_i     (ctl_in2_i),
   .vol_we_o      (vol_we_o),
   .band_clr_o    (band_clr_o),
   .ana_en_o      (ana_en_o),
   .blk_q         (blk_q),
   .alg_restart_o (alg_restart_o),
   .gp_out_o      (gp_out_o)
);

// File: tb/tb_ctlpin_rst_mgr.sv
`timescale 1ns/1ps
module tb_ctlpin_rst_mgr;
   localparam logic [11:0] A_OUT   = 12'hFF0;
   localparam logic [11:0] A_MODE  = 12'hFF1;
   localparam logic [11:0] A_STAT  = 12'hFF2;
   localparam logic [11:0] A_SWRST = 12'hFFD;

   logic        clk = 1'b0;
   logic        rst_pin_n = 1'b0;
   logic        ctl_in1_i = 1'b0;
   logic        ctl_in2_i = 1'b0;
   logic        host_we_i = 1'b0;
   logic [11:0] host_addr_i = 12'h000;
   logic [15:0] host_wdata_i = 16'h0000;
   logic [15:0] host_rdata_o;
   logic        vol_we_o;
   logic [3:0]  vol_idx_o;
   logic [15:0] vol_data_o;
   logic        band_clr_o;
   logic        ana_en_o;
   logic        alg_restart_o;
   logic        sda_hiz_o;
   logic [1:0]  gp_out_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   ctlpin_rst_mgr dut (
      .clk           (clk),
      .rst_pin_n     (rst_pin_n),
      .ctl_in1_i     (ctl_in1_i),
      .ctl_in2_i     (ctl_in2_i),
      .host_we_i     (host_we_i),
      .host_addr_i   (host_addr_i),
      .host_wdata_i  (host_wdata_i),
      .host_rdata_o  (host_rdata_o),
      .vol_we_o      (vol_we_o),
      .vol_idx_o     (vol_idx_o),
      .vol_data_o    (vol_data_o),
      .band_clr_o    (band_clr_o),
      .ana_en_o      (ana_en_o),
      .alg_restart_o (alg_restart_o),
      .sda_hiz_o     (sda_hiz_o),
      .gp_out_o      (gp_out_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      host_we_i = 1'b1; host_addr_i = a; host_wdata_i = d;
      @(negedge clk);
      host_we_i = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [11:0] a);
      host_addr_i = a;
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R7: reset state
      step(3);
      rd(A_STAT);
      chk("R7 restart in reset", alg_restart_o, 1);
      chk("R7 sda release in reset", sda_hiz_o, 1);
      chk("R7 outputs cleared", gp_out_o, 0);
      chk("R7 analyser off", ana_en_o, 0);
      chk("R7 status zero", host_rdata_o, 0);

      // R8: synchronous release
      rst_pin_n = 1'b1;
      step(1);
      chk("R8 restart after 1 edge", alg_restart_o, 1);
      step(1);
      chk("R8 restart after 2 edges", alg_restart_o, 0);
      chk("R8 sda after 2 edges", sda_hiz_o, 0);

      // R5: synchroniser latency
      rd(A_STAT);
      ctl_in1_i = 1'b1; ctl_in2_i = 1'b1;
      step(1);
      chk("R5 not visible after 1 edge", host_rdata_o[1:0], 2'b00);
      step(1);
      chk("R5 visible after 2 edges", host_rdata_o[1:0], 2'b11);
      ctl_in1_i = 1'b0; ctl_in2_i = 1'b0;
      step(2);

      // sweep: analyser mode x output value x input levels
      for (int a = 0; a < 2; a++) begin
         for (int v = 0; v < 4; v++) begin
            for (int lv = 0; lv < 4; lv++) begin
               logic i1, i2;
               logic [15:0] d;
               i1 = lv[0]; i2 = lv[1];
               d  = 16'h1000 + 16'(a * 16 + v * 4 + lv);
               wr(A_MODE, 16'(a));
               wr(A_OUT, 16'(v) | 16'hFFFC);
               ctl_in1_i = i1; ctl_in2_i = i2;
               step(2);
               rd(A_STAT);
               chk("R5 status levels", host_rdata_o[1:0], {i2, i1});
               chk("R3/R4 band clear", band_clr_o, (a == 1) && i2);
               chk("R6 output pins", gp_out_o, v);
               rd(A_OUT);
               chk("R6 output readback", host_rdata_o, v);
               rd(A_MODE);
               chk("R4 mode readback", host_rdata_o, a);
               // volume write attempt
               host_we_i = 1'b1; host_addr_i = 12'h005; host_wdata_i = d;
               #1;
               chk("R1 volume strobe", vol_we_o, !i1);
               chk("R1 volume index", vol_idx_o, 5);
               chk("R1 volume data", vol_data_o, d);
               step(1);
               host_we_i = 1'b0;
               rd(A_STAT);
               chk("R2 sticky set", host_rdata_o[2], i1);
               if (i1) begin
                  ctl_in1_i = 1'b0;
                  step(2);
                  chk("R2 not replayed", vol_we_o, 0);
               end
               wr(A_STAT, 16'h0004);
               rd(A_STAT);
               chk("R2 sticky cleared", host_rdata_o[2], 0);
            end
         end
      end
      ctl_in1_i = 1'b0; ctl_in2_i = 1'b0;
      step(2);

      // R9: software reset keeps mode and sticky, clears outputs
      wr(A_MODE, 16'h0001);
      wr(A_OUT, 16'h0003);
      ctl_in1_i = 1'b1;
      step(2);
      wr(12'h00F, 16'hBEEF);
      ctl_in1_i = 1'b0;
      step(2);
      wr(A_SWRST, 16'h0000);
      chk("R10 no restart", alg_restart_o, 0);
      chk("R10 outputs kept", gp_out_o, 3);
      wr(A_SWRST, 16'h7FFF);
      chk("R10 no restart other bits", alg_restart_o, 0);
      chk("R10 outputs kept other bits", gp_out_o, 3);
      wr(A_SWRST, 16'h8000);
      rd(A_SWRST);
      chk("R9 restart pulse", alg_restart_o, 1);
      chk("R9 bit15 reads 1", host_rdata_o, 16'h8000);
      chk("R9 outputs cleared", gp_out_o, 0);
      chk("R9 sda untouched", sda_hiz_o, 0);
      chk("R9 mode kept", ana_en_o, 1);
      step(1);
      chk("R9 pulse one cycle", alg_restart_o, 0);
      chk("R9 bit15 self-clears", host_rdata_o, 0);
      rd(A_STAT);
      chk("R9 sticky kept", host_rdata_o[2], 1);

      // R7: hardware reset mid-cycle, asynchronous
      wr(A_OUT, 16'h0002);
      #3;
      rst_pin_n = 1'b0;
      #1;
      rd(A_STAT);
      chk("R7 async outputs cleared", gp_out_o, 0);
      chk("R7 async restart", alg_restart_o, 1);
      chk("R7 async sda release", sda_hiz_o, 1);
      chk("R7 async mode cleared", ana_en_o, 0);
      chk("R7 async sticky cleared", host_rdata_o[2], 0);
      step(2);
      rst_pin_n = 1'b1;
      step(3);
      chk("R8 running again", alg_restart_o, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule